// File: doc/BRIEF.md
# On-Chip Memory Window Controller

This block puts a small on-chip RAM behind two programmable address windows, one for the instruction side and one for the data side. Four control registers, reached over a device-control register port, hold a 64 MiB-aligned base address and a control field for each window. Both windows map onto the same physical RAM, so the two sides see each other's data at the same offset.

An access port carries one request per cycle. Two decoders compare the top six address bits against each enabled window. Each decoder drives its own hit output combinationally in the request cycle. If either window claims the access, the RAM performs the read or byte-enabled write at word offset `acc_addr[11:2]`. Read data is registered and appears on the cycle after the request. If no window claims the access, a miss output rises and the RAM is left untouched. The windows are decoded independently, so moving or disabling one window never changes the other, even when both windows share a base.

Top module: `ocm_window_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and every request reports a miss with neither hit asserted.
- R2: Register numbers are 0x018 (instruction base), 0x019 (instruction control), 0x01A (data base) and 0x01B (data control). A write to a base register keeps only data bits 31:26, and all other bits read back as 0.
- R3: A write to a control register keeps only data bits 31:30, and all other bits read back as 0. Bit 31 enables the window.
- R4: Reads of any other register number return 0. Writes to any other register number change no register.
- R5: `cfg_rdata` follows `cfg_addr` combinationally. A register write is visible from the clock edge that samples `cfg_we`.
- R6: `hit_i` (or `hit_d`) is high in the request cycle exactly when `acc_req` is high, that window's enable bit is set, and `acc_addr[31:26]` equals that window's base.
- R7: `miss` is high exactly when `acc_req` is high and neither window hits. A write that misses leaves the RAM contents unchanged.
- R8: A read that hits returns the word at offset `acc_addr[11:2]` on `acc_rdata` one cycle after the request. Otherwise `acc_rdata` holds its previous value.
- R9: A write that hits updates only the byte lanes whose `acc_be` bit is set, where lane n is data bits 8n+7:8n.
- R10: Both windows alias one RAM. A word written through the data window reads back through the instruction window at the same offset.
- R11: When both windows are enabled at the same base, disabling or re-basing the data window leaves the instruction window hitting and reading correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register number |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| acc_req | input | 1 | Memory access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_be | input | 4 | Byte-lane write enables |
| acc_addr | input | 32 | Access byte address |
| acc_wdata | input | 32 | Access write data |
| acc_rdata | output | 32 | Registered read data |
| hit_i | output | 1 | Instruction window claims the access |
| hit_d | output | 1 | Data window claims the access |
| miss | output | 1 | Request claimed by no window |

## Verification
The assertions assume that access inputs are stable during each cycle and are sampled only at the rising edge. They also assume that register writes and accesses may occur in the same cycle, with a hit decision that uses the window settings held before that edge. The stimulus changes every input at the falling edge, one operation per cycle. Addresses are drawn so that their top bits are either the current instruction base, the current data base or a random value, which gives hits, dual hits and misses in steady measure. Register numbers are drawn from the four mapped registers plus one unmapped number.

// File: rtl/ocm_win_pkg.sv
package ocm_win_pkg;
  localparam int N_SIDES = 2;
  localparam int SIDE_I  = 0;
  localparam int SIDE_D  = 1;
  localparam int BASE_W  = 6;
  localparam int CTL_W   = 2;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CTL_W-1:0]  ctl;
  } win_cfg_t;
endpackage

// File: rtl/ocm_win_regs.sv
module ocm_win_regs
  import ocm_win_pkg::*;
#(
  parameter int DCR_AW = 10,
  parameter int DW     = 32,
  parameter logic [DCR_AW-1:0] REG_FIRST = 10'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DCR_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output win_cfg_t          win_o [N_SIDES]
);
  logic [BASE_W-1:0] base_q [N_SIDES];
  logic [BASE_W-1:0] base_d [N_SIDES];
  logic [CTL_W-1:0]  ctl_q  [N_SIDES];
  logic [CTL_W-1:0]  ctl_d  [N_SIDES];
  logic [N_SIDES-1:0] ld_base, ld_ctl;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata[DW-BASE_W-1:0];

  // next state: each side owns an even (base) and odd (control) number
  always_comb begin
    for (int s = 0; s < N_SIDES; s++) begin
      ld_base[s] = cfg_we && (cfg_addr == DCR_AW'(int'(REG_FIRST) + 2*s));
      ld_ctl[s]  = cfg_we && (cfg_addr == DCR_AW'(int'(REG_FIRST) + 2*s + 1));
      base_d[s]  = cfg_wdata[DW-1 -: BASE_W];
      ctl_d[s]   = cfg_wdata[DW-1 -: CTL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SIDES; s++) begin
        base_q[s] <= '0;
        ctl_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < N_SIDES; s++) begin
        if (ld_base[s]) base_q[s] <= base_d[s];
        if (ld_ctl[s])  ctl_q[s]  <= ctl_d[s];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int s = 0; s < N_SIDES; s++) begin
      if (cfg_addr == DCR_AW'(int'(REG_FIRST) + 2*s))
        cfg_rdata[DW-1 -: BASE_W] = base_q[s];
      if (cfg_addr == DCR_AW'(int'(REG_FIRST) + 2*s + 1))
        cfg_rdata[DW-1 -: CTL_W] = ctl_q[s];
    end
  end

  always_comb begin
    for (int s = 0; s < N_SIDES; s++) begin
      win_o[s].base = base_q[s];
      win_o[s].ctl  = ctl_q[s];
    end
  end
endmodule

// File: rtl/ocm_win_match.sv
module ocm_win_match
  import ocm_win_pkg::*;
(
  input  logic              req,
  input  logic [BASE_W-1:0] addr_hi,
  input  win_cfg_t          cfg,
  output logic              hit
);
  logic enabled;
  logic unused_ctl;

  assign enabled    = cfg.ctl[CTL_W-1];
  assign unused_ctl = ^cfg.ctl[CTL_W-2:0];
  assign hit        = req && enabled && (addr_hi == cfg.base);
endmodule

// File: rtl/ocm_win_ram.sv
module ocm_win_ram #(
  parameter int WORDS = 1024,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic rd_en;
  assign rd_en = en && !we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic       wr_en;
    logic [7:0] rd_q;

    assign wr_en = en && we && be[l];

    always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= wdata[8*l +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[idx];
    end

    assign rdata[8*l +: 8] = rd_q;
  end
endmodule

// File: rtl/ocm_window_ctrl.sv
module ocm_window_ctrl
  import ocm_win_pkg::*;
#(
  parameter int DCR_AW    = 10,
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int RAM_WORDS = 1024,
  parameter logic [DCR_AW-1:0] REG_FIRST = 10'h018,
  localparam int IDX_W = $clog2(RAM_WORDS),
  localparam int LANES = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DCR_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [LANES-1:0]  acc_be,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  output logic              hit_i,
  output logic              hit_d,
  output logic              miss
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  win_cfg_t            win_cfg [N_SIDES];
  win_cfg_t            win_i_cfg, win_d_cfg;
  logic [N_SIDES-1:0]  hit_vec;
  logic                any_hit;
  logic [IDX_W-1:0]    ram_idx;
  logic                unused_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ocm_win_regs #(.DCR_AW(DCR_AW), .DW(DW), .REG_FIRST(REG_FIRST)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_o(win_cfg)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    ocm_win_match u_match (
      .req(acc_req), .addr_hi(acc_addr[AW-1 -: BASE_W]),
      .cfg(win_cfg[s]), .hit(hit_vec[s])
    );
  end

  assign win_i_cfg   = win_cfg[SIDE_I];
  assign win_d_cfg   = win_cfg[SIDE_D];
  assign hit_i       = hit_vec[SIDE_I];
  assign hit_d       = hit_vec[SIDE_D];
  assign any_hit     = |hit_vec;
  assign miss        = acc_req && !any_hit;
  assign ram_idx     = acc_addr[IDX_W+1:2];
  assign unused_addr = ^{acc_addr[AW-BASE_W-1:IDX_W+2], acc_addr[1:0]};

  ocm_win_ram #(.WORDS(RAM_WORDS), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_int_n), .en(any_hit), .we(acc_we), .be(acc_be),
    .idx(ram_idx), .wdata(acc_wdata), .rdata(acc_rdata)
  );
endmodule

// File: rtl/ocm_win_chk.sv
module ocm_win_chk
  import ocm_win_pkg::*;
#(
  parameter int DCR_AW = 10,
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter logic [DCR_AW-1:0] REG_FIRST = 10'h018
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [DCR_AW-1:0] cfg_addr,
  input logic [DW-1:0]     cfg_wdata,
  input logic              acc_req,
  input logic              acc_we,
  input logic [AW-1:0]     acc_addr,
  input logic [DW-1:0]     acc_rdata,
  input logic              hit_i,
  input logic              hit_d,
  input logic              miss,
  input win_cfg_t          win_i,
  input win_cfg_t          win_d
);
  logic wr_i_side, wr_ibase, wr_dctl;
  assign wr_ibase  = cfg_we && (cfg_addr == REG_FIRST);
  assign wr_i_side = cfg_we && (cfg_addr == REG_FIRST || cfg_addr == REG_FIRST + 1'b1);
  assign wr_dctl   = cfg_we && (cfg_addr == REG_FIRST + 2'd3);

  // R2
  ibase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ibase |=> win_i.base == $past(cfg_wdata[DW-1 -: BASE_W]));

  // R3
  dctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dctl |=> win_d.ctl == $past(cfg_wdata[DW-1 -: CTL_W]));

  // R11
  iwin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i_side |=> $stable(win_i));

  // R6
  hit_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |-> acc_req && win_i.ctl[CTL_W-1] && acc_addr[AW-1 -: BASE_W] == win_i.base);

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> $countones({hit_i || hit_d, miss}) == 1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> !hit_i && !hit_d && !miss);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && !miss && !acc_we) |=> $stable(acc_rdata));
endmodule

bind ocm_window_ctrl ocm_win_chk #(
  .DCR_AW(DCR_AW), .DW(DW), .AW(AW), .REG_FIRST(REG_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .hit_i(hit_i), .hit_d(hit_d),
  .miss(miss), .win_i(win_i_cfg), .win_d(win_d_cfg)
);

// File: tb/sim_ocm_window_ctrl.sv
module sim_ocm_window_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        hit_i, hit_d, miss;

  int n_chk = 0, n_err = 0;
  logic [5:0]  m_base [2];
  logic [1:0]  m_ctl  [2];
  logic [31:0] m_mem  [1024];
  logic [31:0] last_rd = '0;

  always #2 clk = ~clk;

  ocm_window_ctrl u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input logic [9:0] a);
    case (a)
      10'h018: return {m_base[0], 26'd0};
      10'h019: return {m_ctl[0], 30'd0};
      10'h01A: return {m_base[1], 26'd0};
      10'h01B: return {m_ctl[1], 30'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit exp_hit(input int s, input logic [31:0] a);
    return m_ctl[s][1] && (a[31:26] == m_base[s]);
  endfunction

  task automatic reg_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      10'h018: m_base[0] = d[31:26];
      10'h019: m_ctl[0]  = d[31:30];
      10'h01A: m_base[1] = d[31:26];
      10'h01B: m_ctl[1]  = d[31:30];
      default: ;
    endcase
  endtask

  task automatic reg_chk(input logic [9:0] a, input string tag);
    cfg_addr = a;
    #1;
    check(cfg_rdata === exp_reg(a), tag, cfg_rdata, exp_reg(a));
  endtask

  task automatic acc(input bit we, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input string tag);
    bit hi, hd;
    logic [31:0] w;
    hi = exp_hit(0, a);
    hd = exp_hit(1, a);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_addr = a; acc_be = be; acc_wdata = wd;
    #1;
    check(hit_i === hi, "R6 hit_i", {31'd0, hit_i}, {31'd0, hi});
    check(hit_d === hd, "R6 hit_d", {31'd0, hit_d}, {31'd0, hd});
    check(miss === !(hi || hd), "R7 miss", {31'd0, miss}, {31'd0, !(hi || hd)});
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    #1;
    if ((hi || hd) && !we) last_rd = m_mem[a[11:2]];
    check(acc_rdata === last_rd, tag, acc_rdata, last_rd);
    if ((hi || hd) && we) begin
      w = m_mem[a[11:2]];
      for (int l = 0; l < 4; l++) if (be[l]) w[8*l +: 8] = wd[8*l +: 8];
      m_mem[a[11:2]] = w;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c3a));
    for (int s = 0; s < 2; s++) begin m_base[s] = '0; m_ctl[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 'h18; a <= 'h1B; a++) reg_chk(10'(a), "R1 reset reg");
    acc(1'b0, 32'h0000_0040, 4'hF, 32'd0, "R1 reset read");

    // R2 base masking, R3 control masking, R5 visibility
    reg_wr(10'h018, 32'hFFFF_FFFF); reg_chk(10'h018, "R2 ibase mask");
    reg_wr(10'h01A, 32'h0BAD_F00D); reg_chk(10'h01A, "R2 dbase mask");
    reg_wr(10'h019, 32'hFFFF_FFFF); reg_chk(10'h019, "R3 ictl mask");
    reg_wr(10'h01B, 32'h7FFF_FFFF); reg_chk(10'h01B, "R3 dctl mask R5");
    // R4 unmapped number
    reg_wr(10'h01C, 32'hFFFF_FFFF); reg_chk(10'h01C, "R4 unmapped read");
    for (int a = 'h18; a <= 'h1B; a++) reg_chk(10'(a), "R4 regs unchanged");

    // fill RAM through data window at base 0
    reg_wr(10'h019, 32'h0);
    reg_wr(10'h01A, 32'h0);
    reg_wr(10'h01B, 32'h8000_0000);
    for (int i = 0; i < 1024; i++)
      acc(1'b1, {20'd0, 10'(i), 2'b00}, 4'hF, 32'(i) * 32'h9E37_79B1, "R8 fill");

    // R9 byte lanes
    acc(1'b1, 32'h0000_0010, 4'b0101, 32'hAABB_CCDD, "R9 lane write");
    acc(1'b0, 32'h0000_0010, 4'h0, 32'd0, "R9 lane read");

    // R7 missed write leaves RAM intact
    acc(1'b1, 32'h1000_0020, 4'hF, 32'hDEAD_BEEF, "R7 miss write");
    acc(1'b0, 32'h0000_0020, 4'h0, 32'd0, "R7 after miss");

    // R10 alias: write via data window, read via instruction window
    reg_wr(10'h018, 32'h1400_0000); reg_wr(10'h019, 32'h8000_0000);
    acc(1'b1, 32'h0000_0ABC, 4'hF, 32'h1234_5678, "R10 data write");
    acc(1'b0, 32'h1400_0ABC, 4'h0, 32'd0, "R10 instr read");

    // R11 shared base, then disable and re-base the data window
    reg_wr(10'h01A, 32'h1400_0000);
    acc(1'b0, 32'h1400_0100, 4'h0, 32'd0, "R11 dual hit");
    reg_wr(10'h01B, 32'h0);
    acc(1'b0, 32'h1400_0104, 4'h0, 32'd0, "R11 data off");
    reg_wr(10'h01B, 32'h8000_0000); reg_wr(10'h01A, 32'h2400_0000);
    acc(1'b0, 32'h1400_0108, 4'h0, 32'd0, "R11 data moved");
    acc(1'b0, 32'h2400_0108, 4'h0, 32'd0, "R11 new data base");

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op == 0) begin
        logic [9:0] ra;
        logic [31:0] rd;
        ra = 10'h018 + 10'($urandom % 5);
        rd = $urandom;
        if (ra == 10'h019 || ra == 10'h01B) rd[31] = ($urandom % 4) != 0;
        reg_wr(ra, rd);
        reg_chk(ra, "R5 random reg");
      end else begin
        logic [31:0] a;
        int pick;
        pick = int'($urandom % 3);
        a = $urandom;
        if (pick == 0) a[31:26] = m_base[0];
        else if (pick == 1) a[31:26] = m_base[1];
        acc(op < 4, a, 4'($urandom), $urandom, "R8 random access");
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule